// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block deserialises stereo PCM from a three-wire serial audio link: a bit clock, a frame clock that separates the left and right halves of each sample period, and a data line. The link signals are sampled by the system clock, so the bit clock must run well below it. Every active bit clock edge is found by edge detection after a short synchroniser. Static configuration inputs select the framing format, how the frame clock is read, which bit clock edge samples the data, and the word length on the wire.

Each received word is normalised to a fixed signed output width, 24 bits by default. Short words are placed MSB-first with zeros below them. Long words lose their low-order bits. A left/right pair is presented together with a single-cycle valid strobe once the right word is complete. After reset the block ignores the link until it sees the first frame boundary, and it starts counting bits from there.

Top module: `serial_audio_rx`

## Requirements
- R1: Format code 01 is left-justified. With the polarity input at 0, the left word occupies the half where the frame clock is high, and its MSB is the first bit sampled after the frame clock changes.
- R2: Format code 10 is I2S. With the polarity input at 0, the left word occupies the half where the frame clock is low, and its MSB is the second bit sampled after the frame clock changes.
- R3: Format code 00 is right-justified. The LSB of each word is the last bit sampled before the frame clock changes. With the polarity input at 0, left is the frame clock high half.
- R4: In formats 00, 01 and 10, a polarity input of 1 swaps which frame clock level carries the left word.
- R5: Format code 11 is DSP framing. A frame clock pulse of one bit period marks the frame start, and the right word follows the left word with no gap. With the polarity input at 0 (mode A) the left MSB is the bit after the pulse bit. With it at 1 (mode B) the left MSB is the pulse bit itself.
- R6: With the edge-select input at 0, the frame clock and data are sampled on rising bit clock edges. With it at 1, they are sampled on falling edges.
- R7: Word-length codes 00, 01, 10 and 11 select 16, 20, 24 and 32 bits. 16-bit and 20-bit words are output MSB-aligned with zero low bits. The low 8 bits of a 32-bit word are dropped. The sign bit is kept in the output MSB.
- R8: The combination of right-justified format and 32-bit word length raises the configuration-error output, and no valid strobe is produced while it holds.
- R9: The left and right outputs change only in the cycle that valid is high. Valid is high for exactly one cycle per frame, and it reports the left and right words of that same frame.
- R10: During and after reset, left, right and valid are zero. No sample is produced until a frame boundary has been seen on the link.
- R11: In I2S format with 24-bit length, a shorter word followed by zero bits within the half is output MSB-aligned with zero low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; link signals are sampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock |
| frame_i | input | 1 | Frame (left/right) clock or DSP frame pulse |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Framing: 00 right-justified, 01 left-justified, 10 I2S, 11 DSP |
| lr_pol_i | input | 1 | Frame clock inversion, or DSP mode select (0 A, 1 B) |
| bclk_fall_i | input | 1 | 0 samples on rising bit clock edges, 1 on falling |
| wlen_i | input | 2 | Word length: 00 16, 01 20, 10 24, 11 32 bits |
| left_o | output | OUT_W | Left sample, signed |
| right_o | output | OUT_W | Right sample, signed |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |
| cfg_err_o | output | 1 | Unsupported format/length combination selected |

## Verification
The bench keeps the default parameters: a 24-bit output and a two-stage synchroniser. The 24-bit output puts both directions of normalisation within reach, zero padding for 16 and 20-bit words and truncation for 32-bit words, and it allows the I2S short-word case. With the bit clock held for three system cycles per level, the synchroniser latency stays well inside a bit period, so a wrong sampling edge shows up as a one-bit shift of the received word.

// File: rtl/sar_pkg.sv
package sar_pkg;

   localparam int WORD_MAX = 32;

   typedef enum logic [1:0] {
      FMT_RJ  = 2'b00,
      FMT_LJ  = 2'b01,
      FMT_I2S = 2'b10,
      FMT_DSP = 2'b11
   } frame_fmt_e;

   // number of bits on the wire for a word-length code
   function automatic logic [5:0] word_bits(input logic [1:0] code);
      case (code)
         2'b00:   return 6'd16;
         2'b01:   return 6'd20;
         2'b10:   return 6'd24;
         default: return 6'd32;
      endcase
   endfunction

endpackage

// File: rtl/sar_edge_pick.sv
module sar_edge_pick #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_i,
   input  logic frame_i,
   input  logic sdata_i,
   input  logic fall_sel,
   output logic strobe_o,
   output logic frame_o,
   output logic sdata_o
);
   localparam int LAST = SYNC_STAGES - 1;

   // bit 2 bit clock, bit 1 frame, bit 0 data
   logic [2:0] stage [SYNC_STAGES];
   logic       bclk_prev;

   generate
      for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stage[g] <= 3'b000;
               else        stage[g] <= {bclk_i, frame_i, sdata_i};
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stage[g] <= 3'b000;
               else        stage[g] <= stage[g-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) bclk_prev <= 1'b0;
      else        bclk_prev <= stage[LAST][2];

   assign strobe_o = (stage[LAST][2] != bclk_prev) && (stage[LAST][2] == ~fall_sel);
   assign frame_o  = stage[LAST][1];
   assign sdata_o  = stage[LAST][0];

endmodule

// File: rtl/sar_slot_track.sv
module sar_slot_track
   import sar_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       strobe,
   input  logic       frame,
   input  logic [1:0] fmt,
   input  logic       lr_pol,
   input  logic [1:0] wlen,
   output logic       shift_en,
   output logic       done,
   output logic       done_pre,
   output logic       done_right,
   output logic       armed_o,
   output logic       bad_cfg
);
   localparam int CNT_W = $clog2(2 * WORD_MAX + 3);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   logic             half_prev, frame_prev, armed_q;
   logic [CNT_W-1:0] idx_q, idx_now, wb, off;
   logic             is_dsp, half_left, boundary, armed_now;

   always_comb begin
      is_dsp    = (fmt == FMT_DSP);
      half_left = (fmt == FMT_I2S) ? (~frame ^ lr_pol) : (frame ^ lr_pol);
      boundary  = is_dsp ? (frame & ~frame_prev) : (half_left != half_prev);
      idx_now   = boundary ? '0 : ((idx_q == CNT_TOP) ? idx_q : idx_q + 1'b1);
      armed_now = armed_q | boundary;
      wb        = CNT_W'(word_bits(wlen));
      off       = ((fmt == FMT_I2S) || (is_dsp && !lr_pol)) ? CNT_W'(1) : '0;
      bad_cfg   = (fmt == FMT_RJ) && (wlen == 2'b11);

      shift_en   = 1'b0;
      done       = 1'b0;
      done_pre   = 1'b0;
      done_right = 1'b0;
      if (strobe && !bad_cfg) begin
         case (fmt)
            FMT_RJ: begin
               shift_en = 1'b1;
               if (boundary && armed_q) begin
                  done       = 1'b1;
                  done_pre   = 1'b1;
                  done_right = ~half_prev;
               end
            end
            FMT_DSP: begin
               if (armed_now && idx_now >= off && idx_now < off + (wb << 1)) begin
                  shift_en = 1'b1;
                  if (idx_now == off + wb - 1'b1) begin
                     done = 1'b1;
                  end else if (idx_now == off + (wb << 1) - 1'b1) begin
                     done       = 1'b1;
                     done_right = 1'b1;
                  end
               end
            end
            default: begin
               if (armed_now && idx_now >= off && idx_now < off + wb) begin
                  shift_en = 1'b1;
                  if (idx_now == off + wb - 1'b1) begin
                     done       = 1'b1;
                     done_right = ~half_left;
                  end
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         half_prev  <= 1'b0;
         frame_prev <= 1'b0;
         idx_q      <= '0;
         armed_q    <= 1'b0;
      end else if (strobe) begin
         half_prev  <= half_left;
         frame_prev <= frame;
         idx_q      <= idx_now;
         armed_q    <= armed_now;
      end

   assign armed_o = armed_q;

endmodule

// File: rtl/sar_word_pack.sv
module sar_word_pack
   import sar_pkg::*;
#(
   parameter int OUT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sdata,
   input  logic             shift_en,
   input  logic             done,
   input  logic             done_pre,
   input  logic             done_right,
   input  logic [1:0]       wlen,
   output logic [OUT_W-1:0] left_o,
   output logic [OUT_W-1:0] right_o,
   output logic             valid_o
);
   localparam int SH_W = $clog2(WORD_MAX + 1);

   logic [WORD_MAX-1:0] sr_q, sr_next, src, aligned;
   logic [SH_W-1:0]     lift;
   logic [OUT_W-1:0]    sample, left_hold;
   logic                left_seen;

   always_comb begin
      sr_next = {sr_q[WORD_MAX-2:0], sdata};
      src     = done_pre ? sr_q : sr_next;
      lift    = SH_W'(WORD_MAX) - SH_W'(word_bits(wlen));
      aligned = src << lift;                 // word MSB at top, zeros below
      sample  = OUT_W'(aligned >> (WORD_MAX - OUT_W));
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         sr_q      <= '0;
         left_hold <= '0;
         left_seen <= 1'b0;
         left_o    <= '0;
         right_o   <= '0;
         valid_o   <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (shift_en) sr_q <= sr_next;
         if (done) begin
            if (!done_right) begin
               left_hold <= sample;
               left_seen <= 1'b1;
            end else if (left_seen) begin
               left_o    <= left_hold;
               right_o   <= sample;
               valid_o   <= 1'b1;
               left_seen <= 1'b0;
            end
         end
      end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
   import sar_pkg::*;
#(
   parameter int OUT_W       = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bclk_i,
   input  logic             frame_i,
   input  logic             sdata_i,
   input  logic [1:0]       fmt_i,
   input  logic             lr_pol_i,
   input  logic             bclk_fall_i,
   input  logic [1:0]       wlen_i,
   output logic [OUT_W-1:0] left_o,
   output logic [OUT_W-1:0] right_o,
   output logic             valid_o,
   output logic             cfg_err_o
);
   generate
      if (OUT_W < 8 || OUT_W > WORD_MAX) begin : g_bad_width
         $error("OUT_W must lie between 8 and the widest word");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic strobe, frame_s, sdata_s;
   logic shift_en, done, done_pre, done_right, armed;

   sar_edge_pick #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .bclk_i   (bclk_i),
      .frame_i  (frame_i),
      .sdata_i  (sdata_i),
      .fall_sel (bclk_fall_i),
      .strobe_o (strobe),
      .frame_o  (frame_s),
      .sdata_o  (sdata_s)
   );

   sar_slot_track u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe     (strobe),
      .frame      (frame_s),
      .fmt        (fmt_i),
      .lr_pol     (lr_pol_i),
      .wlen       (wlen_i),
      .shift_en   (shift_en),
      .done       (done),
      .done_pre   (done_pre),
      .done_right (done_right),
      .armed_o    (armed),
      .bad_cfg    (cfg_err_o)
   );

   sar_word_pack #(.OUT_W(OUT_W)) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .sdata      (sdata_s),
      .shift_en   (shift_en),
      .done       (done),
      .done_pre   (done_pre),
      .done_right (done_right),
      .wlen       (wlen_i),
      .left_o     (left_o),
      .right_o    (right_o),
      .valid_o    (valid_o)
   );

endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
   parameter int OUT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             valid_o,
   input logic [OUT_W-1:0] left_o,
   input logic [OUT_W-1:0] right_o,
   input logic             cfg_err_o,
   input logic             armed
);
   // R9
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R9
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({left_o, right_o}) |-> valid_o);

   // R8
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err_o && $past(cfg_err_o)) |-> !valid_o);

   // R10
   sync_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(armed));

endmodule

bind serial_audio_rx serial_audio_rx_chk #(.OUT_W(OUT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .valid_o   (valid_o),
   .left_o    (left_o),
   .right_o   (right_o),
   .cfg_err_o (cfg_err_o),
   .armed     (armed)
);

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;
   localparam int HB = 3;       // system cycles per bit clock level
   localparam int H  = 34;      // bit clocks per frame half

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b0, frame = 1'b0, sdata = 1'b0;
   logic [1:0]  fmt = 2'b01, wlen = 2'b10;
   logic        lr_pol = 1'b0, bclk_fall = 1'b0;
   logic [23:0] left_o, right_o;
   logic        valid_o, cfg_err_o;

   int vectors = 0, fails = 0, n_got = 0, run_len = 0, max_run = 0;
   bit finished = 0;
   logic [23:0] got_l [4];
   logic [23:0] got_r [4];
   logic [31:0] wl_words [2] = '{32'hA5C3_9E71, 32'h1B2C_3D4E};
   logic [31:0] wr_words [2] = '{32'h5A1B_2C8D, 32'hF0E1_D2C3};

   always #10 clk = ~clk;

   serial_audio_rx u_serial_audio_rx (
      .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .frame_i(frame), .sdata_i(sdata),
      .fmt_i(fmt), .lr_pol_i(lr_pol), .bclk_fall_i(bclk_fall), .wlen_i(wlen),
      .left_o(left_o), .right_o(right_o), .valid_o(valid_o), .cfg_err_o(cfg_err_o));

   always @(negedge clk) begin
      if (valid_o) begin
         if (n_got < 4) begin
            got_l[n_got] = left_o;
            got_r[n_got] = right_o;
         end
         n_got++;
         run_len++;
         if (run_len > max_run) max_run = run_len;
      end else begin
         run_len = 0;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // word of nb bits, placed MSB first in 24 bits
   function automatic logic [23:0] expect_out(input logic [31:0] w, input int nb);
      logic [31:0] top;
      top = w << (32 - nb);
      return top[31:8];
   endfunction

   task automatic bit_out(input logic f, input logic d);
      bclk  = bclk_fall;        // inactive level
      frame = f;
      sdata = d;
      repeat (HB) @(negedge clk);
      bclk = ~bclk_fall;        // sampling edge
      repeat (HB) @(negedge clk);
   endtask

   task automatic do_reset(input logic [1:0] f, input logic p, input logic e, input logic [1:0] wl);
      @(negedge clk);
      rst_n = 1'b0;
      fmt = f; lr_pol = p; bclk_fall = e; wlen = wl;
      bclk = e; frame = 1'b0; sdata = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      n_got = 0; max_run = 0;
      repeat (2) @(negedge clk);
   endtask

   // frame clock level for a half: left or right
   function automatic logic half_level(input logic left);
      logic lvl;
      lvl = (fmt == 2'b10) ? ~left : left;
      return lvl ^ lr_pol;
   endfunction

   task automatic send_half(input logic left, input logic [31:0] w, input int nb, input logic fill);
      for (int i = 0; i < H; i++) begin
         logic d;
         case (fmt)
            2'b00:   d = (i >= H - nb) ? w[H-1-i] : fill;
            2'b10:   d = (i >= 1 && i <= nb) ? w[nb-i] : fill;
            default: d = (i < nb) ? w[nb-1-i] : fill;
         endcase
         bit_out(half_level(left), d);
      end
   endtask

   task automatic send_dsp(input logic [31:0] l, input logic [31:0] r, input int nb);
      int off;
      off = lr_pol ? 0 : 1;
      for (int i = 0; i < 2 * nb + 4; i++) begin
         int k;
         logic d;
         k = i - off;
         if (k >= 0 && k < nb)           d = l[nb-1-k];
         else if (k >= nb && k < 2 * nb) d = r[2*nb-1-k];
         else                            d = 1'b1;
         bit_out(i == 0, d);
      end
   endtask

   // two frames, then compare both pairs
   task automatic run_stream(input string tag, input logic [1:0] f, input logic p,
                             input logic e, input logic [1:0] wl, input int nb, input logic fill);
      do_reset(f, p, e, wl);
      for (int i = 0; i < 3; i++)
         if (f == 2'b11) bit_out(1'b0, 1'b1); else bit_out(half_level(1'b0), 1'b1);
      for (int fr = 0; fr < 2; fr++) begin
         if (f == 2'b11) send_dsp(wl_words[fr], wr_words[fr], nb);
         else begin
            send_half(1'b1, wl_words[fr], nb, fill);
            send_half(1'b0, wr_words[fr], nb, fill);
         end
      end
      for (int i = 0; i < 3; i++)
         if (f == 2'b11) bit_out(1'b0, 1'b1); else bit_out(half_level(1'b1), 1'b1);
      repeat (10) @(negedge clk);
      chk({tag, " pair count"}, n_got, 2);
      chk({tag, " R9 single-cycle valid"}, max_run, 1);
      chk({tag, " cfg_err low"}, cfg_err_o, 0);
      for (int fr = 0; fr < 2; fr++) begin
         chk({tag, " left"},  got_l[fr], expect_out(wl_words[fr], nb));
         chk({tag, " right"}, got_r[fr], expect_out(wr_words[fr], nb));
      end
   endtask

   task automatic test_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10 left in reset", left_o, 0);
      chk("R10 right in reset", right_o, 0);
      chk("R10 valid in reset", valid_o, 0);
      do_reset(2'b01, 1'b0, 1'b0, 2'b00);
      // no frame boundary: constant right level with data toggling
      for (int i = 0; i < 60; i++) bit_out(1'b0, i[0]);
      repeat (6) @(negedge clk);
      chk("R10 no pair before boundary", n_got, 0);
      chk("R10 left after idle", left_o, 0);
   endtask

   task automatic test_bad_cfg;
      do_reset(2'b00, 1'b0, 1'b0, 2'b11);
      for (int fr = 0; fr < 3; fr++) begin
         for (int i = 0; i < 40; i++) bit_out(1'b1, i[1]);
         for (int i = 0; i < 40; i++) bit_out(1'b0, i[2]);
      end
      repeat (6) @(negedge clk);
      chk("R8 cfg_err raised", cfg_err_o, 1);
      chk("R8 no pair", n_got, 0);
   endtask

   initial begin
      repeat (150000) @(negedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      test_reset();
      run_stream("R1 R7 LJ 24-bit",           2'b01, 1'b0, 1'b0, 2'b10, 24, 1'b1);
      run_stream("R2 R7 I2S 16-bit",          2'b10, 1'b0, 1'b0, 2'b00, 16, 1'b1);
      run_stream("R3 R7 RJ 20-bit",           2'b00, 1'b0, 1'b0, 2'b01, 20, 1'b1);
      run_stream("R4 R7 LJ inverted 32-bit",  2'b01, 1'b1, 1'b0, 2'b11, 32, 1'b1);
      run_stream("R4 R6 I2S inverted falling",2'b10, 1'b1, 1'b1, 2'b10, 24, 1'b1);
      run_stream("R3 R4 R6 RJ inverted fall", 2'b00, 1'b1, 1'b1, 2'b10, 24, 1'b1);
      run_stream("R5 DSP mode A 24-bit",      2'b11, 1'b0, 1'b0, 2'b10, 24, 1'b1);
      run_stream("R5 R6 DSP mode B 16-bit",   2'b11, 1'b1, 1'b1, 2'b00, 16, 1'b1);
      run_stream("R5 R7 DSP mode B 32-bit",   2'b11, 1'b1, 1'b0, 2'b11, 32, 1'b1);
      run_stream("R11 I2S 18-bit in 24",      2'b10, 1'b0, 1'b0, 2'b10, 18, 1'b0);
      test_bad_cfg();
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule